// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Front End

This block is a synchronous model of the register front end of a four-channel converter with a parallel bus. Each channel has two paths. The code path carries a 16-bit output code and the range path carries a 3-bit range selector. Each path has a staging register and a live register, so a channel holds four registers and the block holds sixteen.

A host puts a value on the shared bus, sets the path select and the channel address, and drives the active-low write strobe low. The value goes into the staging register of the chosen path. A rising edge on the commit strobe then copies every staging register into its live register, on all channels, in one clock. Range and code therefore change together, and several channels change on the same cycle.

Holding the write strobe low while the commit strobe is high makes both stages transparent. Driving both strobes from one signal gives edge-triggered loading: the staging register loads while the signal is low and the live register loads when it rises. An asynchronous clear sets every code register to the code that gives zero output in its channel's live range. The clear leaves the range registers alone. Each commit edge raises a one-cycle settle-start pulse.

Top module: `dacif_quad`

## Requirements
- R1: After reset, every live code output and every live range output is 0, and the settle-start pulse is low.
- R2: A cycle with the write strobe low and the path select low loads the bus into the staging code register of the addressed channel. No live output changes until a commit.
- R3: A cycle with the write strobe low and the path select high loads bus bits [2:0] into the staging range register of the addressed channel. The other bus bits are ignored.
- R4: A commit strobe that is high in a cycle after a low cycle copies staging code and staging range into the live registers of every channel at that clock edge. A channel with no write since the last commit keeps its live values.
- R5: Address codes 0 to 3 select channels 0 to 3. A write to address codes 4 to 7 changes no register.
- R6: A cycle with the write strobe low and the commit strobe high (flow-through) writes the bus value straight into the live register. The value is on the output after that single clock edge.
- R7: The settle-start output is high for exactly one cycle, in the cycle after the clock edge that samples the commit strobe's rising edge. It stays low while the commit strobe is held high.
- R8: Driving the clear low asynchronously sets the staging and live code registers of each channel to that channel's zero code. The zero code depends on the live range code: 0x0000 for codes 0, 1, 6 and 7 (unipolar), 0x8000 for codes 2, 3 and 4 (symmetric bipolar), and 0x4000 for code 5 (offset bipolar). Range registers do not change, and a later commit with no write leaves the cleared code in place.
- R9: When both strobes come from one signal, a low cycle loads only the staging register. The next rising edge moves the value to the live output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low code clear |
| wr_n | input | 1 | Active-low write strobe |
| span_sel | input | 1 | Path select: 0 selects code, 1 selects range |
| addr | input | 3 | Channel address |
| bus | input | 16 | Shared parallel data bus |
| upd | input | 1 | Commit strobe, acts on its rising edge |
| dac_code | output | 64 | Live codes, channel n in bits [16n+15:16n] |
| dac_span | output | 12 | Live range codes, channel n in bits [3n+2:3n] |
| deglitch_start | output | 1 | One-cycle settle-start pulse |

## Verification
The hardest case to reach is a clear that arrives when the channels hold different live ranges. Each channel must then fall to a different zero code, and the staging registers must be cleared as well. To get there, the stimulus first commits a symmetric range on one channel, an offset range on another and unipolar ranges on the rest. It then pulses the clear between two clock edges and reads all four codes before the next edge. Finally it commits with no write, to show that the staging registers were cleared along with the live ones.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   localparam int SPAN_W = 3;

   typedef enum logic [SPAN_W-1:0] {
      RNG_UNI_LO  = 3'd0,
      RNG_UNI_HI  = 3'd1,
      RNG_SYM_MID = 3'd2,
      RNG_SYM_HI  = 3'd3,
      RNG_SYM_LO  = 3'd4,
      RNG_OFFSET  = 3'd5,
      RNG_SPARE6  = 3'd6,
      RNG_SPARE7  = 3'd7
   } range_e;

   typedef enum logic [1:0] {
      ZK_BOTTOM,
      ZK_HALF,
      ZK_QUARTER
   } zero_kind_e;

   function automatic zero_kind_e range_zero_kind(input logic [SPAN_W-1:0] rng);
      zero_kind_e k;
      case (range_e'(rng))
         RNG_SYM_MID, RNG_SYM_HI, RNG_SYM_LO: k = ZK_HALF;
         RNG_OFFSET:                          k = ZK_QUARTER;
         default:                             k = ZK_BOTTOM;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/dacif_strobe.sv
module dacif_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n,
   input  logic upd,
   output logic wr_act,
   output logic upd_lvl,
   output logic upd_rise,
   output logic deglitch_start
);

   logic upd_q;

   assign wr_act   = ~wr_n;
   assign upd_lvl  = upd;
   assign upd_rise = upd & ~upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q          <= 1'b0;
         deglitch_start <= 1'b0;
      end else begin
         upd_q          <= upd;
         deglitch_start <= upd_rise;
      end
   end

   // R7: the pulse never lasts two cycles
   assert_deglitch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      deglitch_start |=> !deglitch_start);

   // R7: the pulse follows a cycle in which the commit strobe was high
   assert_deglitch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deglitch_start) |-> $past(upd));

endmodule

// File: rtl/dacif_addr_dec.sv
module dacif_addr_dec #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_act,
   input  logic              span_sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] wr_code_en,
   output logic [NUM_CH-1:0] wr_rng_en
);

   localparam int ADDR_SPACE = 1 << ADDR_W;

   if (NUM_CH > ADDR_SPACE) begin : g_bad_space
      $error("dacif_addr_dec: NUM_CH exceeds the address space");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit           = wr_act && (int'(addr) == c);
      assign wr_code_en[c] = hit && !span_sel;
      assign wr_rng_en[c]  = hit &&  span_sel;
   end

   // R5: at most one staging register is written per cycle
   assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_code_en, wr_rng_en}));

   // R5: an address outside the channel range writes nothing
   assert_bad_addr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) >= NUM_CH) |-> (wr_code_en == '0 && wr_rng_en == '0));

endmodule

// File: rtl/dacif_channel.sv
module dacif_channel
   import dacif_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit FLOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              wr_code,
   input  logic              wr_rng,
   input  logic [DATA_W-1:0] bus,
   input  logic              upd_lvl,
   input  logic              upd_rise,
   output logic [DATA_W-1:0] code_live,
   output logic [SPAN_W-1:0] rng_live
);

   localparam logic [DATA_W-1:0] CODE_HALF    = DATA_W'(1) << (DATA_W - 1);
   localparam logic [DATA_W-1:0] CODE_QUARTER = DATA_W'(1) << (DATA_W - 2);

   logic [DATA_W-1:0] code_stage, code_stage_nx, code_src, code_zero;
   logic [SPAN_W-1:0] rng_stage, rng_stage_nx, rng_src;
   logic              load_live;

   assign code_stage_nx = wr_code ? bus : code_stage;
   assign rng_stage_nx  = wr_rng  ? bus[SPAN_W-1:0] : rng_stage;

   if (FLOW_EN) begin : g_flow
      // live stage is transparent while the commit strobe is high
      assign load_live = upd_lvl;
      assign code_src  = code_stage_nx;
      assign rng_src   = rng_stage_nx;
   end else begin : g_edge
      assign load_live = upd_rise;
      assign code_src  = code_stage;
      assign rng_src   = rng_stage;
   end

   always_comb begin
      case (range_zero_kind(rng_live))
         ZK_HALF:    code_zero = CODE_HALF;
         ZK_QUARTER: code_zero = CODE_QUARTER;
         default:    code_zero = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n) begin
         code_stage <= '0;
         code_live  <= '0;
      end else if (!clr_n) begin
         code_stage <= code_zero;
         code_live  <= code_zero;
      end else begin
         code_stage <= code_stage_nx;
         if (load_live) code_live <= code_src;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rng_stage <= '0;
         rng_live  <= '0;
      end else begin
         rng_stage <= rng_stage_nx;
         if (load_live) rng_live <= rng_src;
      end
   end

   // R4: the live range holds while the commit strobe is low
   assert_rng_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_lvl |=> $stable(rng_live));

   // R8: a held clear keeps the live code at the zero code of the live range
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (code_live == ((range_zero_kind(rng_live) == ZK_HALF) ? CODE_HALF :
                                (range_zero_kind(rng_live) == ZK_QUARTER) ? CODE_QUARTER :
                                DATA_W'(0))));

endmodule

// File: rtl/dacif_quad.sv
module dacif_quad
   import dacif_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter bit FLOW_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_n,
   input  logic                     wr_n,
   input  logic                     span_sel,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        bus,
   input  logic                     upd,
   output logic [NUM_CH*DATA_W-1:0] dac_code,
   output logic [NUM_CH*SPAN_W-1:0] dac_span,
   output logic                     deglitch_start
);

   if (DATA_W < SPAN_W + 1) begin : g_bad_width
      $error("dacif_quad: DATA_W too small to carry a range code");
   end
   if (NUM_CH < 1) begin : g_bad_count
      $error("dacif_quad: NUM_CH must be at least 1");
   end

   logic              wr_act, upd_lvl, upd_rise;
   logic [NUM_CH-1:0] wr_code_en, wr_rng_en;

   dacif_strobe u_strobe (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_n           (wr_n),
      .upd            (upd),
      .wr_act         (wr_act),
      .upd_lvl        (upd_lvl),
      .upd_rise       (upd_rise),
      .deglitch_start (deglitch_start)
   );

   dacif_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_act     (wr_act),
      .span_sel   (span_sel),
      .addr       (addr),
      .wr_code_en (wr_code_en),
      .wr_rng_en  (wr_rng_en)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dacif_channel #(.DATA_W(DATA_W), .FLOW_EN(FLOW_EN)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_n     (clr_n),
         .wr_code   (wr_code_en[c]),
         .wr_rng    (wr_rng_en[c]),
         .bus       (bus),
         .upd_lvl   (upd_lvl),
         .upd_rise  (upd_rise),
         .code_live (dac_code[c*DATA_W +: DATA_W]),
         .rng_live  (dac_span[c*SPAN_W +: SPAN_W])
      );
   end

endmodule

// File: tb/dacif_quad_tb_top.sv
module dacif_quad_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        span_sel = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] bus = '0;
   logic        upd = 1'b0;
   logic [63:0] dac_code;
   logic [11:0] dac_span;
   logic        deglitch_start;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dacif_quad dut_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_n(wr_n),
      .span_sel(span_sel), .addr(addr), .bus(bus), .upd(upd),
      .dac_code(dac_code), .dac_span(dac_span), .deglitch_start(deglitch_start)
   );

   typedef struct packed {
      logic        wr_n;
      logic        sel;
      logic [2:0]  addr;
      logic [15:0] bus;
      logic        upd;
      logic [1:0]  ch;
      logic [15:0] code;
      logic [2:0]  rng;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{1'b0, 1'b0, 3'd0, 16'h1234, 1'b0, 2'd0, 16'h0000, 3'd0, 4'd2}, // R2 staged only
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 2'd0, 16'h1234, 3'd0, 4'd4}, // R4 commit
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 2'd0, 16'h1234, 3'd0, 4'd4}, // R4 holds
      '{1'b0, 1'b1, 3'd1, 16'hFFFB, 1'b0, 2'd1, 16'h0000, 3'd0, 4'd3}, // R3 staged range
      '{1'b0, 1'b0, 3'd1, 16'hABCD, 1'b0, 2'd1, 16'h0000, 3'd0, 4'd2}, // R2 staged code
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 2'd1, 16'hABCD, 3'd3, 4'd3}, // R3 range lsbs
      '{1'b0, 1'b0, 3'd2, 16'h0F0F, 1'b0, 2'd0, 16'h1234, 3'd0, 4'd2}, // R2 other chan
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 2'd2, 16'h0F0F, 3'd0, 4'd4}, // R4 commit ch2
      '{1'b0, 1'b0, 3'd3, 16'h5555, 1'b1, 2'd3, 16'h5555, 3'd0, 4'd6}, // R6 flow-through
      '{1'b0, 1'b0, 3'd5, 16'h7777, 1'b0, 2'd3, 16'h5555, 3'd0, 4'd5}, // R5 bad address
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 2'd1, 16'hABCD, 3'd3, 4'd5}, // R5 no alias ch1
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b0, 2'd3, 16'h5555, 3'd0, 4'd5}, // R5 ch3 intact
      '{1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 2'd1, 16'hABCD, 3'd3, 4'd4}  // R4 no-write commit
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic s, input logic [2:0] a,
                        input logic [15:0] b, input logic u);
      wr_n = w; span_sel = s; addr = a; bus = b; upd = u;
      @(negedge clk);
   endtask

   function automatic logic [15:0] code_of(input int c);
      return dac_code[c*16 +: 16];
   endfunction

   function automatic logic [2:0] rng_of(input int c);
      return dac_span[c*3 +: 3];
   endfunction

   initial begin
      #(CLK_PERIOD*20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 code", {32'(dac_code[31:0])}, 32'h0);
      chk("R1 code hi", {32'(dac_code[63:32])}, 32'h0);
      chk("R1 range", 32'(dac_span), 32'h0);
      chk("R1 pulse", 32'(deglitch_start), 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].wr_n, VT[i].sel, VT[i].addr, VT[i].bus, VT[i].upd);
         chk($sformatf("R%0d vec%0d code", VT[i].req, i), 32'(code_of(VT[i].ch)), 32'(VT[i].code));
         chk($sformatf("R%0d vec%0d range", VT[i].req, i), 32'(rng_of(VT[i].ch)), 32'(VT[i].rng));
      end

      // R7 settle-start pulse timing
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b0);
      chk("R7 low", 32'(deglitch_start), 32'h0);
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b1);
      chk("R7 pulse", 32'(deglitch_start), 32'h1);
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b1);
      chk("R7 held", 32'(deglitch_start), 32'h0);

      // set channel 2 to the offset range (code 5)
      drive(1'b0, 1'b1, 3'd2, 16'h0005, 1'b0);
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b1);
      chk("R4 ch2 range", 32'(rng_of(2)), 32'h5);
      chk("R4 ch2 code", 32'(code_of(2)), 32'h0F0F);

      // R8 asynchronous clear between clock edges
      #2 clr_n = 1'b0;
      #1;
      chk("R8 ch0 unipolar", 32'(code_of(0)), 32'h0000);
      chk("R8 ch1 symmetric", 32'(code_of(1)), 32'h8000);
      chk("R8 ch2 offset", 32'(code_of(2)), 32'h4000);
      chk("R8 ch3 unipolar", 32'(code_of(3)), 32'h0000);
      chk("R8 ranges kept", 32'(dac_span), {20'h0, 3'd0, 3'd5, 3'd3, 3'd0});
      #1 clr_n = 1'b1;
      @(negedge clk);
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b0);
      drive(1'b1, 1'b0, 3'd0, 16'h0, 1'b1);
      chk("R8 staged cleared", 32'(code_of(1)), 32'h8000);

      // R9 strobes tied together
      drive(1'b0, 1'b0, 3'd0, 16'h2222, 1'b0);
      chk("R9 low phase", 32'(code_of(0)), 32'h0000);
      drive(1'b1, 1'b0, 3'd0, 16'h0000, 1'b1);
      chk("R9 rising", 32'(code_of(0)), 32'h2222);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule